// File: doc/BRIEF.md
# Windowed Watchdog with Delayed Reset

This block supervises a processor from a dedicated watchdog clock that has no relation to the processor clock. A falling edge on the active-low start line opens a first service window. A service pulse inside that window closes it and starts a frame window. Each frame begins with a closed guard span, in which a service pulse counts as too early. The rest of the frame is open, and a service pulse there restarts the guard and the frame. If a window runs out, or a service pulse arrives while the window is closed, the block raises a fail flag. After a fixed delay it also drives a reset output. In that delay software can store debug data before the reset takes effect.

Each window counts coarse ticks from its own free-running divider, so the main counters and comparators stay narrow. A fast-clock offset counter measures the gap between the window's start and its first tick, then counts back down after the last tick. Every window therefore lasts an exact number of watchdog-clock cycles, whatever the divider phase was when the window started. Window lengths come from preset tables chosen by two select inputs.

The state machine has six states. IDLE waits for a start edge. SVC is the first open service window. GUARD is the closed head of a frame. OPEN is the open rest of a frame. HOLD is the fault with only the flag raised. RESET is the fault with the reset output also driven. The transitions are:
- start: any state to SVC.
- serve: SVC to GUARD, and OPEN to GUARD.
- unguard: GUARD to OPEN.
- expire or early: SVC, GUARD or OPEN to HOLD.
- delay-done: HOLD to RESET.
- clear: HOLD or RESET to IDLE.

Top module: `wdt_windowed`

## Requirements
- R1: After reset is released, fail_flag, rst_out, svc_open and frm_active are all 0 and the block is idle. A start line held low through reset does not count as a falling edge.
- R2: When init_n is sampled 1 and then 0 on consecutive clock edges, the block is in the first service window from the next cycle on (svc_open=1). This happens from any state, and fail_flag and rst_out drop in that same cycle.
- R3: The first service window lasts exactly (SW_BASE << sw_sel) * SW_DIV cycles, whatever the tick phase. With the default parameters that is 16, 32, 64 or 128 cycles for sw_sel 0 to 3. If no service arrives, fail_flag is 1 in the cycle after the last window cycle.
- R4: A service pulse in any cycle of the first service window, including its last cycle, closes the window. From the next cycle, svc_open=0, frm_active=1 and fail_flag=0.
- R5: A frame window lasts exactly (FW_BASE << fw_sel) * FW_DIV cycles from the service that started it. With the default parameters that is 64, 128, 256 or 512 cycles. Its first (SW_BASE << sw_sel) * SW_DIV cycles are a closed guard (svc_open=0), and the remaining cycles are open (svc_open=1). If the frame ends before a service, including an end that falls inside the guard, fail_flag is 1 in the next cycle.
- R6: A service pulse during the guard raises fail_flag in the next cycle.
- R7: A service pulse in the open part of a frame, including the frame's last cycle, starts a new guard and a new full-length frame from the next cycle.
- R8: rst_out rises exactly FAIL_DLY cycles after fail_flag rises (10 with the default parameters).
- R9: Once raised, fail_flag and rst_out hold until a clr_fault pulse returns the block to idle in the next cycle, or until a start edge (R2). A start edge takes priority over clr_fault.
- R10: A service pulse while idle has no effect: all outputs stay 0.
- R11: The select inputs are sampled when a window starts. Changing them during a window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wd | input | 1 | Dedicated watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Start line; a falling edge opens the first service window |
| svc_pulse | input | 1 | Service (kick) strobe, one cycle |
| clr_fault | input | 1 | Clears a held fault back to idle |
| sw_sel | input | SEL_W | Service-window preset select |
| fw_sel | input | SEL_W | Frame-window preset select |
| fail_flag | output | 1 | Fault indication, raised first |
| rst_out | output | 1 | Reset output, raised FAIL_DLY cycles after the flag |
| svc_open | output | 1 | A service pulse is currently accepted |
| frm_active | output | 1 | A frame window is running |

## Verification
A service pulse and a window expiry can land in the same cycle. In the last cycle of the first service window, and in the last cycle of a frame, the service counts as on time. In the last guard cycle it still counts as early. The directed tests place the pulse on exactly the final cycle. They confirm that the block moves to a fresh guard and shows no fault, and the frame case then waits a full new frame before checking the expiry. Because each window's length is fixed in cycles and not in ticks, the bench can predict every edge without knowing the divider phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SVC   = 3'd1,
        ST_GUARD = 3'd2,
        ST_OPEN  = 3'd3,
        ST_HOLD  = 3'd4,
        ST_RESET = 3'd5
    } wdt_state_t;

    typedef enum logic [1:0] {
        PH_UP   = 2'd0,
        PH_MAIN = 2'd1,
        PH_DOWN = 2'd2
    } tmr_phase_t;

endpackage

// File: rtl/wdt_window_timer.sv
module wdt_window_timer #(
    parameter int DIV       = 8,
    parameter int MAX_TICKS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           run,
    input  logic [$clog2(MAX_TICKS+1)-1:0] len,
    output logic                           expire
);
    import wdt_pkg::*;

    localparam int OW = $clog2(DIV);
    localparam int MW = $clog2(MAX_TICKS + 1);

    logic [OW-1:0] pre_q;
    logic          tick;
    logic [OW-1:0] off_q, off_d;
    logic [MW-1:0] main_q, main_d;
    logic [MW-1:0] len_q;
    tmr_phase_t    ph_q, ph_d;

    // free-running slow tick divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (pre_q == OW'(DIV - 1)) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + OW'(1);
        end
    end
    assign tick = (pre_q == OW'(DIV - 1));

    always_comb begin
        off_d  = off_q;
        main_d = main_q;
        ph_d   = ph_q;
        expire = 1'b0;
        if (run) begin
            unique case (ph_q)
                PH_UP, PH_MAIN: begin
                    if (tick) begin
                        if (main_q + MW'(1) == len_q) begin
                            main_d = main_q + MW'(1);
                            if (off_q == OW'(DIV - 1)) begin
                                expire = 1'b1;
                            end else begin
                                off_d = OW'(DIV - 2) - off_q;
                                ph_d  = PH_DOWN;
                            end
                        end else begin
                            main_d = main_q + MW'(1);
                            ph_d   = PH_MAIN;
                        end
                    end else if (ph_q == PH_UP) begin
                        off_d = off_q + OW'(1);
                    end
                end
                PH_DOWN: begin
                    if (off_q == '0) begin
                        expire = 1'b1;
                    end else begin
                        off_d = off_q - OW'(1);
                    end
                end
                default: ph_d = PH_UP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            main_q <= '0;
            len_q  <= '0;
            ph_q   <= PH_UP;
        end else if (start) begin
            off_q  <= '0;
            main_q <= '0;
            len_q  <= len;
            ph_q   <= PH_UP;
        end else begin
            off_q  <= off_d;
            main_q <= main_d;
            ph_q   <= ph_d;
        end
    end

    assert_down_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DOWN) |-> (off_q <= OW'(DIV - 2)));

    assert_main_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ph_q != PH_UP) |-> (main_q <= len_q));

endmodule

// File: rtl/wdt_fail_delay.sv
module wdt_fail_delay #(
    parameter int DLY = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(DLY);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == CW'(DLY - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assert_delay_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (!run || cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed #(
    parameter int SEL_W    = 2,
    parameter int SW_DIV   = 8,
    parameter int SW_BASE  = 2,
    parameter int FW_DIV   = 16,
    parameter int FW_BASE  = 4,
    parameter int FAIL_DLY = 10
) (
    input  logic             clk_wd,
    input  logic             rst_n,
    input  logic             init_n,
    input  logic             svc_pulse,
    input  logic             clr_fault,
    input  logic [SEL_W-1:0] sw_sel,
    input  logic [SEL_W-1:0] fw_sel,
    output logic             fail_flag,
    output logic             rst_out,
    output logic             svc_open,
    output logic             frm_active
);
    import wdt_pkg::*;

    localparam int SW_MAXN = SW_BASE << ((1 << SEL_W) - 1);
    localparam int FW_MAXN = FW_BASE << ((1 << SEL_W) - 1);
    localparam int SW_MW   = $clog2(SW_MAXN + 1);
    localparam int FW_MW   = $clog2(FW_MAXN + 1);

    wdt_state_t state_q, state_d;
    logic       init_q, init_fall;
    logic       sw_start, fw_start, sw_run, fw_run, sw_exp, fw_exp;
    logic       dly_run, dly_done;
    logic [SW_MW-1:0] sw_len;
    logic [FW_MW-1:0] fw_len;

    assign sw_len = SW_MW'(SW_BASE) << sw_sel;
    assign fw_len = FW_MW'(FW_BASE) << fw_sel;

    always_ff @(posedge clk_wd or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= 1'b0;
        end else begin
            init_q <= init_n;
        end
    end
    assign init_fall = init_q && !init_n;

    assign sw_run  = (state_q == ST_SVC) || (state_q == ST_GUARD);
    assign fw_run  = (state_q == ST_GUARD) || (state_q == ST_OPEN);
    assign dly_run = (state_q == ST_HOLD);

    wdt_window_timer #(.DIV(SW_DIV), .MAX_TICKS(SW_MAXN)) i_sw_timer (
        .clk(clk_wd), .rst_n(rst_n), .start(sw_start), .run(sw_run),
        .len(sw_len), .expire(sw_exp)
    );

    wdt_window_timer #(.DIV(FW_DIV), .MAX_TICKS(FW_MAXN)) i_fw_timer (
        .clk(clk_wd), .rst_n(rst_n), .start(fw_start), .run(fw_run),
        .len(fw_len), .expire(fw_exp)
    );

    wdt_fail_delay #(.DLY(FAIL_DLY)) i_fail_delay (
        .clk(clk_wd), .rst_n(rst_n), .run(dly_run), .done(dly_done)
    );

    // next-state and timer launch decisions
    always_comb begin
        state_d  = state_q;
        sw_start = 1'b0;
        fw_start = 1'b0;
        if (init_fall) begin
            state_d  = ST_SVC;
            sw_start = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_SVC: begin
                    if (svc_pulse) begin
                        state_d  = ST_GUARD;
                        sw_start = 1'b1;
                        fw_start = 1'b1;
                    end else if (sw_exp) begin
                        state_d = ST_HOLD;
                    end
                end
                ST_GUARD: begin
                    if (svc_pulse || fw_exp) begin
                        state_d = ST_HOLD;
                    end else if (sw_exp) begin
                        state_d = ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (svc_pulse) begin
                        state_d  = ST_GUARD;
                        sw_start = 1'b1;
                        fw_start = 1'b1;
                    end else if (fw_exp) begin
                        state_d = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (clr_fault) begin
                        state_d = ST_IDLE;
                    end else if (dly_done) begin
                        state_d = ST_RESET;
                    end
                end
                ST_RESET: begin
                    if (clr_fault) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_wd or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fail_flag  = 1'b0;
        rst_out    = 1'b0;
        svc_open   = 1'b0;
        frm_active = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SVC:   svc_open = 1'b1;
            ST_GUARD: frm_active = 1'b1;
            ST_OPEN: begin
                svc_open   = 1'b1;
                frm_active = 1'b1;
            end
            ST_HOLD:  fail_flag = 1'b1;
            ST_RESET: begin
                fail_flag = 1'b1;
                rst_out   = 1'b1;
            end
            default: ;
        endcase
    end

    assert_start_opens_R2: assert property (@(posedge clk_wd) disable iff (!rst_n)
        init_fall |=> (svc_open && !fail_flag && !rst_out));

    assert_serve_closes_R4: assert property (@(posedge clk_wd) disable iff (!rst_n)
        (state_q == ST_SVC && svc_pulse && !init_fall) |=> (frm_active && !svc_open && !fail_flag));

    assert_early_faults_R6: assert property (@(posedge clk_wd) disable iff (!rst_n)
        (state_q == ST_GUARD && svc_pulse && !init_fall) |=> fail_flag);

    assert_flag_first_R8: assert property (@(posedge clk_wd) disable iff (!rst_n)
        $rose(rst_out) |-> $past(fail_flag));

    assert_fault_holds_R9: assert property (@(posedge clk_wd) disable iff (!rst_n)
        (fail_flag && !clr_fault && !init_fall) |=> fail_flag);

    assert_idle_ignores_R10: assert property (@(posedge clk_wd) disable iff (!rst_n)
        (state_q == ST_IDLE && !init_fall) |=> !fail_flag);

endmodule

// File: tb/test_wdt_windowed.sv
module test_wdt_windowed;

    logic       clk_wd = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_n = 1'b1;
    logic       svc_pulse = 1'b0;
    logic       clr_fault = 1'b0;
    logic [1:0] sw_sel = 2'd0;
    logic [1:0] fw_sel = 2'd0;
    logic       fail_flag, rst_out, svc_open, frm_active;

    int checks = 0;
    int failures = 0;
    int nidx = 0;

    always #5 clk_wd = ~clk_wd;

    wdt_windowed i_wdt_windowed (
        .clk_wd(clk_wd), .rst_n(rst_n), .init_n(init_n), .svc_pulse(svc_pulse),
        .clr_fault(clr_fault), .sw_sel(sw_sel), .fw_sel(fw_sel),
        .fail_flag(fail_flag), .rst_out(rst_out), .svc_open(svc_open),
        .frm_active(frm_active)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at step %0d: actual=%b expected=%b", req, what, nidx, act, exp);
        end
    endtask

    task automatic goto_step(input int k);
        while (nidx < k) begin
            @(negedge clk_wd);
            nidx++;
        end
    endtask

    task automatic start_edge();
        @(negedge clk_wd);
        init_n = 1'b0;
        @(negedge clk_wd);
        init_n = 1'b1;
        nidx = 1;
    endtask

    task automatic serve();
        svc_pulse = 1'b1;
        @(negedge clk_wd);
        nidx++;
        svc_pulse = 1'b0;
    endtask

    task automatic clear();
        clr_fault = 1'b1;
        @(negedge clk_wd);
        nidx++;
        clr_fault = 1'b0;
    endtask

    task automatic t_reset_and_idle();
        chk("R1", "fail_flag", fail_flag, 1'b0);
        chk("R1", "rst_out", rst_out, 1'b0);
        chk("R1", "svc_open", svc_open, 1'b0);
        chk("R1", "frm_active", frm_active, 1'b0);
        @(negedge clk_wd);
        serve();
        goto_step(nidx + 3);
        chk("R10", "fail_flag after idle service", fail_flag, 1'b0);
        chk("R10", "frm_active after idle service", frm_active, 1'b0);
    endtask

    task automatic t_service_expiry_and_delay();
        sw_sel = 2'd0;
        start_edge();
        chk("R2", "svc_open after start", svc_open, 1'b1);
        sw_sel = 2'd3;
        goto_step(16);
        chk("R3", "svc_open last cycle", svc_open, 1'b1);
        chk("R11", "no fault at last cycle", fail_flag, 1'b0);
        goto_step(17);
        chk("R3", "fail after 16-cycle window", fail_flag, 1'b1);
        chk("R8", "rst_out not yet", rst_out, 1'b0);
        goto_step(26);
        chk("R8", "rst_out one before delay", rst_out, 1'b0);
        goto_step(27);
        chk("R8", "rst_out after delay", rst_out, 1'b1);
        goto_step(60);
        chk("R9", "fail held", fail_flag, 1'b1);
        chk("R9", "rst held", rst_out, 1'b1);
        clear();
        chk("R9", "fail cleared", fail_flag, 1'b0);
        chk("R9", "rst cleared", rst_out, 1'b0);
        chk("R9", "idle after clear", svc_open, 1'b0);
    endtask

    task automatic t_last_cycle_service();
        sw_sel = 2'd1;
        start_edge();
        goto_step(32);
        serve();
        chk("R4", "frame after last-cycle service", frm_active, 1'b1);
        chk("R4", "window closed", svc_open, 1'b0);
        chk("R4", "no fault", fail_flag, 1'b0);
        goto_step(40);
        serve();
        chk("R6", "early service faults", fail_flag, 1'b1);
        goto_step(50);
        chk("R8", "rst before delay", rst_out, 1'b0);
        goto_step(51);
        chk("R8", "rst after delay", rst_out, 1'b1);
        start_edge();
        chk("R2", "start clears fault", fail_flag, 1'b0);
        chk("R2", "start clears rst", rst_out, 1'b0);
        chk("R2", "start opens window", svc_open, 1'b1);
    endtask

    task automatic t_frame_restart();
        sw_sel = 2'd0;
        fw_sel = 2'd1;
        start_edge();
        goto_step(5);
        serve();
        chk("R4", "frame running", frm_active, 1'b1);
        goto_step(21);
        chk("R5", "guard closed last cycle", svc_open, 1'b0);
        goto_step(22);
        chk("R5", "open after guard", svc_open, 1'b1);
        goto_step(40);
        serve();
        chk("R7", "guard restarted", svc_open, 1'b0);
        goto_step(168);
        chk("R7", "no expiry of old frame", fail_flag, 1'b0);
        serve();
        chk("R7", "last-cycle frame service", fail_flag, 1'b0);
        chk("R7", "frame still active", frm_active, 1'b1);
        goto_step(296);
        chk("R5", "frame not yet expired", fail_flag, 1'b0);
        goto_step(297);
        chk("R5", "frame expiry faults", fail_flag, 1'b1);
        clear();
        chk("R9", "clear after frame fault", fail_flag, 1'b0);
    endtask

    task automatic t_frame_shorter_than_guard();
        sw_sel = 2'd3;
        fw_sel = 2'd0;
        start_edge();
        goto_step(3);
        serve();
        goto_step(67);
        chk("R5", "still guarded", svc_open, 1'b0);
        chk("R5", "no fault yet", fail_flag, 1'b0);
        goto_step(68);
        chk("R5", "frame ends inside guard", fail_flag, 1'b1);
        clr_fault = 1'b1;
        start_edge();
        clr_fault = 1'b0;
        chk("R9", "start wins over clear", svc_open, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_wd);
        rst_n = 1'b1;
        @(negedge clk_wd);
        t_reset_and_idle();
        t_service_expiry_and_delay();
        t_last_cycle_service();
        t_frame_restart();
        t_frame_shorter_than_guard();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule